// File: doc/BRIEF.md
# Dual-Clock Streaming FIFO

This block carries a stream of data words from one clock domain into a second clock domain that has no fixed phase or frequency relation to the first. A producer pushes words with a write enable in its own clock. A consumer pops them with a read enable in its own clock. The words sit in a register array that is written on the producer clock and read on the consumer clock, so the data itself never passes through a synchronizer.

Each side keeps a binary position counter that is one bit wider than the array address. The counter is turned into Gray code and registered. Only that Gray register is sent across, through a two-flop synchronizer. The producer side compares its own next position with the synchronized consumer position to raise a registered full flag. The consumer side does the same against the synchronized producer position to raise a registered empty flag. Both flags are pessimistic: they can stay set a few cycles after space or data appears, but they never clear early. The read data port always shows the oldest unread word while empty is low.

Top module: `xclk_stream_fifo`

## Requirements
- R1: While reset is held, and after reset with no traffic, empty reads 1 and full reads 0.
- R2: Words leave in the order they were accepted. While empty is 0, rdData shows the oldest unread word, and a read accepted at a read-clock edge removes that word.
- R3: A write requested while full is 1 is dropped: the word is not stored and the write position does not move.
- R4: A read requested while empty is 1 is dropped: no word is consumed and the read position does not move.
- R5: Full is never 0 while DEPTH unread words are held. Once traffic stops with DEPTH words held, full reads 1.
- R6: Empty is never 0 while no unread word is held. Once traffic stops with nothing held, empty reads 1.
- R7: Each position sent to the other domain is a register in Gray code that changes by at most one bit per clock of its own domain.
- R8: A write is accepted on every write clock while full is 0, and a read is accepted on every read clock while empty is 0, so each side can move one word per clock.
- R9: After one word is written into an empty FIFO, empty clears within 4 read-clock edges. After one word is read from a full FIFO, full clears within 4 write-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Producer clock |
| wrRstN | input | 1 | Producer-side asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | No room; writes are dropped while set |
| rdClk | input | 1 | Consumer clock |
| rdRstN | input | 1 | Consumer-side asynchronous reset, active low |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Oldest unread word, valid while rdEmpty is 0 |
| rdEmpty | output | 1 | No data; reads are dropped while set |

## Verification
If a position counter moves on a dropped request, the fault shows at rdData on the next accepted read of the affected slot: a word goes missing, is repeated, or is overwritten before it is read. A position that crosses incoherently, or a flag that clears too early, lets full or empty drop while the true fill level is at its limit. The reference model flags that in the same cycle. A flag that stays set too long shows as a missed latency bound within four clock edges, or as a shortfall in the number of accepted transfers during streaming.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // Which flag a pointer unit produces.
  typedef enum logic {
    SIDE_WR = 1'b0,
    SIDE_RD = 1'b1
  } side_e;

  // Strobe from a pointer unit to the storage datapath.
  typedef struct packed {
    logic fire;   // a transfer is accepted on this clock edge
  } strobe_t;

endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/xfifo_ptr.sv
// Position counter and flag for one side of the FIFO. SIDE picks full or empty.
module xfifo_ptr
  import xfifo_pkg::*;
#(
  parameter int    ADDR_W = 3,   // must be 2 or more
  parameter side_e SIDE   = SIDE_WR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W:0]   remoteGray,
  output logic              flag,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   localGray,
  output strobe_t           strobe
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] bin;
  logic [PTR_W-1:0] binNext;
  logic [PTR_W-1:0] grayNext;
  logic             flagNext;
  logic             fire;

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  assign fire     = req && !flag;
  assign binNext  = bin + PTR_W'(fire);
  assign grayNext = binNext ^ (binNext >> 1);

  generate
    if (SIDE == SIDE_WR) begin : g_full
      // Full: the writer is one lap ahead, so the top two Gray bits differ.
      assign flagNext = (grayNext == {~remoteGray[PTR_W-1:PTR_W-2],
                                      remoteGray[PTR_W-3:0]});
    end else begin : g_empty
      assign flagNext = (grayNext == remoteGray);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bin       <= '0;
      localGray <= '0;
      flag      <= (SIDE == SIDE_RD);
    end else begin
      bin       <= binNext;
      localGray <= grayNext;
      flag      <= flagNext;
    end
  end

  assign addr        = bin[ADDR_W-1:0];
  assign strobe.fire = fire;

  // R7: the position sent across changes by at most one bit per clock.
  p_gray_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(localGray ^ $past(localGray)) <= 1));

  logic [PTR_W-1:0] remoteBin;
  assign remoteBin = grayToBin(remoteGray);

  generate
    if (SIDE == SIDE_WR) begin : g_wr_checks
      logic [PTR_W-1:0] span;
      assign span = bin - remoteBin;

      // R3: a write asked for while full leaves the position alone.
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
        (req && flag) |=> (bin == $past(bin)));

      // R5: the writer never gets more than DEPTH ahead of what it has seen read.
      p_span_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
        span <= PTR_W'(DEPTH));
    end else begin : g_rd_checks
      logic [PTR_W-1:0] span;
      assign span = remoteBin - bin;

      // R4: a read asked for while empty leaves the position alone.
      p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
        (req && flag) |=> (bin == $past(bin)));

      // R6: the reader never passes the write position it has seen.
      p_span_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
        span <= PTR_W'(DEPTH));
    end
  endgenerate

endmodule

// File: rtl/xfifo_store.sv
// Word storage: written on the producer clock, read by address on the consumer side.
module xfifo_store
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  strobe_t           wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  strobe_t           rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrStrobe.fire) begin
      slots[wrAddr] <= wrData;
    end
  end

  assign rdData = slots[rdAddr];

  // R2: an accepted read only ever takes a slot that already holds a word.
  p_take_written_r2: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdStrobe.fire |-> !$isunknown(rdData));

endmodule

// File: rtl/xclk_stream_fifo.sv
module xclk_stream_fifo
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);

  localparam int PTR_W = ADDR_W + 1;

  strobe_t           wrStrobe;
  strobe_t           rdStrobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [PTR_W-1:0]  wrGray;
  logic [PTR_W-1:0]  rdGray;
  logic [PTR_W-1:0]  wrGrayAtRd;
  logic [PTR_W-1:0]  rdGrayAtWr;

  xfifo_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_WR)) wrSide (
    .clk        (wrClk),
    .rstN       (wrRstN),
    .req        (wrEn),
    .remoteGray (rdGrayAtWr),
    .flag       (wrFull),
    .addr       (wrAddr),
    .localGray  (wrGray),
    .strobe     (wrStrobe)
  );

  xfifo_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_RD)) rdSide (
    .clk        (rdClk),
    .rstN       (rdRstN),
    .req        (rdEn),
    .remoteGray (wrGrayAtRd),
    .flag       (rdEmpty),
    .addr       (rdAddr),
    .localGray  (rdGray),
    .strobe     (rdStrobe)
  );

  // Only registered Gray positions enter the synchronizers.
  xfifo_sync2 #(.W(PTR_W)) wrToRd (
    .clk  (rdClk),
    .rstN (rdRstN),
    .d    (wrGray),
    .q    (wrGrayAtRd)
  );

  xfifo_sync2 #(.W(PTR_W)) rdToWr (
    .clk  (wrClk),
    .rstN (wrRstN),
    .d    (rdGray),
    .q    (rdGrayAtWr)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store (
    .wrClk    (wrClk),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdClk    (rdClk),
    .rdRstN   (rdRstN),
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: tb/xclk_stream_fifo_test.sv
`timescale 1ns/1ps
module xclk_stream_fifo_test;

  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          wrRstN, rdRstN;
  logic          wrEn, rdEn;
  logic [DW-1:0] wrData, rdData;
  logic          wrFull, rdEmpty;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] model[$];
  int wrMode = 0;   // 0 idle, 1 every clock, 2 random, 3 single word
  int rdMode = 0;
  int wAcc   = 0;
  int rAcc   = 0;
  int base;

  always #2.5 wrClk = ~wrClk;   // 200 MHz producer clock
  always #3.5 rdClk = ~rdClk;   // unrelated consumer clock

  xclk_stream_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(posedge rdClk);
    repeat (12) @(posedge wrClk);
    #0.7;
  endtask

  // Producer driver and model update
  initial begin : writer
    bit acc;
    wrEn = 1'b0;
    wrData = '0;
    forever begin
      @(negedge wrClk);
      wrEn   = (wrMode == 1) || (wrMode == 3) || (wrMode == 2 && $urandom_range(1, 0) == 1);
      wrData = DW'($urandom);
      if (!wrFull) chk(model.size() < DEPTH, "R5", "full low at limit", model.size(), DEPTH - 1);
      acc = wrEn && !wrFull && wrRstN;
      @(posedge wrClk);
      if (acc) begin
        model.push_back(wrData);
        wAcc++;
        if (wrMode == 3) wrMode = 0;
      end
    end
  end

  // Consumer driver, data compare and model update
  initial begin : reader
    bit acc;
    int expV;
    rdEn = 1'b0;
    forever begin
      @(negedge rdClk);
      rdEn = (rdMode == 1) || (rdMode == 3) || (rdMode == 2 && $urandom_range(1, 0) == 1);
      if (!rdEmpty) chk(model.size() > 0, "R6", "empty low with nothing held", model.size(), 1);
      if (rdEn && !rdEmpty) begin
        expV = (model.size() > 0) ? int'(model[0]) : -1;
        chk(int'(rdData) == expV, "R2", "read word", rdData, expV);
      end
      acc = rdEn && !rdEmpty && rdRstN;
      @(posedge rdClk);
      if (acc) begin
        if (model.size() > 0) void'(model.pop_front());
        rAcc++;
        if (rdMode == 3) rdMode = 0;
      end
    end
  end

  initial begin : watchdog
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    wrRstN = 1'b0;
    rdRstN = 1'b0;
    repeat (3) @(posedge rdClk);
    @(negedge wrClk);
    chk(wrFull == 1'b0, "R1", "full in reset", wrFull, 0);
    chk(rdEmpty == 1'b1, "R1", "empty in reset", rdEmpty, 1);
    @(posedge wrClk);
    #0.7;
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    settle();
    chk(wrFull == 1'b0, "R1", "full after reset", wrFull, 0);
    chk(rdEmpty == 1'b1, "R1", "empty after reset", rdEmpty, 1);

    // Fill: one write per clock until full, then keep pushing (R8, R3, R5)
    @(posedge wrClk);
    #0.7;
    base = wAcc;
    wrMode = 1;
    repeat (DEPTH) @(posedge wrClk);
    #0.7;
    chk(wAcc - base == DEPTH, "R8", "writes in first DEPTH clocks", wAcc - base, DEPTH);
    repeat (6) @(posedge wrClk);
    #0.7;
    wrMode = 0;
    settle();
    chk(wrFull == 1'b1, "R5", "full when DEPTH held", wrFull, 1);
    chk(wAcc - base == DEPTH, "R3", "writes accepted while full", wAcc - base, DEPTH);
    chk(model.size() == DEPTH, "R3", "words held", model.size(), DEPTH);

    // One read from full: full must clear within 4 write edges (R9)
    rdMode = 3;
    wait (rdMode == 0);
    repeat (4) @(posedge wrClk);
    @(negedge wrClk);
    chk(wrFull == 1'b0, "R9", "full clear latency", wrFull, 0);
    settle();
    chk(model.size() == DEPTH - 1, "R2", "words after one read", model.size(), DEPTH - 1);

    // Drain and keep reading while empty (R4, R6)
    rdMode = 1;
    repeat (DEPTH + 10) @(posedge rdClk);
    rdMode = 0;
    settle();
    chk(rdEmpty == 1'b1, "R6", "empty after drain", rdEmpty, 1);
    chk(rAcc == wAcc, "R4", "reads accepted vs words written", rAcc, wAcc);

    // One write into empty: empty must clear within 4 read edges (R9)
    wrMode = 3;
    wait (wrMode == 0);
    repeat (4) @(posedge rdClk);
    @(negedge rdClk);
    chk(rdEmpty == 1'b0, "R9", "empty clear latency", rdEmpty, 0);
    rdMode = 3;
    wait (rdMode == 0);
    settle();
    chk(rdEmpty == 1'b1, "R4", "empty after single word", rdEmpty, 1);
    chk(model.size() == 0, "R4", "words held", model.size(), 0);

    // Streaming: reader must take a word on every read clock (R8)
    wrMode = 1;
    rdMode = 1;
    repeat (20) @(posedge rdClk);
    #0.1;
    base = rAcc;
    repeat (50) @(posedge rdClk);
    #0.1;
    chk(rAcc - base == 50, "R8", "reads in 50 clocks", rAcc - base, 50);

    // Random traffic on both sides (R2, R5, R6 checked every clock)
    wrMode = 2;
    rdMode = 2;
    repeat (3000) @(posedge wrClk);
    #0.7;
    wrMode = 0;
    rdMode = 1;
    repeat (DEPTH + 20) @(posedge rdClk);
    rdMode = 0;
    settle();
    chk(rdEmpty == 1'b1, "R6", "empty after random run", rdEmpty, 1);
    chk(wrFull == 1'b0, "R5", "full after random run", wrFull, 0);
    chk(rAcc == wAcc, "R2", "all written words read", rAcc, wAcc);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule